// File: doc/BRIEF.md
# Instruction Machine-Cycle Sequencer

This block steps a small 8-bit processor core through the machine cycles of each instruction. It sits above a bus cycle generator. For every machine cycle it presents a cycle-type code and a 16-bit address. It holds them steady until the generator reports completion with a one-clock `busDone` strobe, and it takes the byte returned on `busData` in that same clock. The generator decides how many clock states each cycle lasts: four for an opcode fetch and three for a memory read. The total state count of an instruction therefore follows from the sequence of cycle types that this block issues.

Two opcodes are decoded. Opcode 0xC6 adds an immediate byte to the accumulator. Opcode 0x3A loads the accumulator from a direct 16-bit address, which arrives in the instruction stream low byte first. Every other opcode runs as a one-cycle no-operation. The block exposes the following on its ports: the current machine-cycle number, the program counter, the instruction register, the temporary address register, the accumulator and a carry flag. A one-clock completion pulse lets the surrounding logic count the clock states of each instruction.

Top module: `mcycle_sequencer`

## Requirements
- R1: While `rst` is high (synchronous, active high) and in the first clock after it, the program counter, accumulator, carry, instruction register and temporary address are all zero, `mCycle` is 1, `cycType` is 3'b011 and `busAddr` is 0x0000.
- R2: Machine cycle 1 of every instruction is an opcode fetch, with `cycType` = 3'b011 at the program-counter address. The fetched byte is loaded into the instruction register.
- R3: Every machine cycle after the first is a memory read, with `cycType` = 3'b010.
- R4: Opcode 0xC6 runs an opcode fetch and then one read of the operand at the next address (4+3 = 7 clock states). The accumulator becomes (accumulator + operand) mod 256, and carry is set to 1 exactly when the sum exceeds 255.
- R5: Opcode 0x3A runs four cycles (4+3+3+3 = 13 clock states). Cycle 2 reads the low address byte and cycle 3 reads the high address byte into the temporary address register. Cycle 4 reads at that assembled address, and the byte read goes into the accumulator. Carry is left unchanged.
- R6: The program counter advances by one after each opcode or operand byte is read. It does not advance after the cycle-4 data read.
- R7: Any opcode other than 0xC6 and 0x3A takes a single fetch cycle (4 clock states) and advances the program counter by one. The accumulator and carry are left unchanged.
- R8: `mCycle` numbers the machine cycles of an instruction 1, 2, 3, 4. It changes only in the clock after `busDone`, and `cycType` and `busAddr` hold steady within a cycle.
- R9: `instrDone` is high for exactly one clock: the clock after `busDone` of an instruction's last machine cycle.
- R10: Raising `rst` in the middle of an instruction abandons it. Sequencing restarts with a fetch at address 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busDone | input | 1 | One-clock strobe: the current machine cycle has completed |
| busData | input | 8 | Byte returned by the cycle that completes with busDone |
| cycType | output | 3 | Requested cycle type: 3'b011 opcode fetch, 3'b010 memory read |
| busAddr | output | 16 | Address of the requested cycle |
| mCycle | output | 3 | Current machine-cycle number, 1 to 4 |
| pc | output | 16 | Program counter |
| ir | output | 8 | Instruction register |
| tmpAddr | output | 16 | Temporary address assembled by load-direct |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry out of the last add-immediate |
| instrDone | output | 1 | One-clock pulse after an instruction's final cycle |

## Verification
The bench targets add-immediate sums that land exactly on 256. A design that takes the carry from the wrong bit, or clears it, would show the wrong carry and a non-zero accumulator. Load-direct is run with distinct, non-zero high and low address bytes, and also at 0x0000 and 0xFFFF. The bench memory XORs the high address byte into the data it returns, so swapping the byte order or dropping the high byte changes the loaded value. The bench measures clock states between completion pulses, so an extra or missing cycle, or a wrong cycle type, changes the 7/13/4 totals. The program-counter values after each instruction expose a stray increment after the data read. A reset in the middle of a load-direct must restart cleanly at address zero.

// File: rtl/mcycle_seq_pkg.sv
package mcycle_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CYC_W  = 3;
  localparam int MC_W   = 3;

  // cycle-type codes seen by the bus cycle generator
  localparam logic [CYC_W-1:0] CYC_FETCH = 3'b011;
  localparam logic [CYC_W-1:0] CYC_READ  = 3'b010;

  localparam logic [DATA_W-1:0] OP_ADDIMM  = 8'hC6;
  localparam logic [DATA_W-1:0] OP_LOADDIR = 8'h3A;

  typedef enum logic [MC_W-1:0] {
    MC1 = 3'd1,
    MC2 = 3'd2,
    MC3 = 3'd3,
    MC4 = 3'd4
  } mcyc_t;

  // strobes from control to datapath, valid together with busDone
  typedef struct packed {
    logic loadIr;
    logic incPc;
    logic addAcc;
    logic loadAcc;
    logic loadLo;
    logic loadHi;
    logic useTmp;   // address source: 1 = temporary address, 0 = program counter
  } seqStrobe_t;
endpackage

// File: rtl/mcycle_seq_control.sv
module mcycle_seq_control
  import mcycle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] irQ,
  output seqStrobe_t        strobe,
  output logic [CYC_W-1:0]  cycType,
  output logic [MC_W-1:0]   mCycle,
  output logic              instrDone
);
  mcyc_t curCyc, nextCyc;
  logic  lastCyc;

  // the opcode is decoded from the bus in cycle 1, from the instruction register later
  always_comb begin
    strobe  = '0;
    nextCyc = MC1;
    lastCyc = 1'b0;
    unique case (curCyc)
      MC1: begin
        strobe.loadIr = 1'b1;
        strobe.incPc  = 1'b1;
        if (busData == OP_ADDIMM || busData == OP_LOADDIR) nextCyc = MC2;
        else lastCyc = 1'b1;
      end
      MC2: begin
        strobe.incPc = 1'b1;
        if (irQ == OP_ADDIMM) begin
          strobe.addAcc = 1'b1;
          lastCyc       = 1'b1;
        end else begin
          strobe.loadLo = 1'b1;
          nextCyc       = MC3;
        end
      end
      MC3: begin
        strobe.loadHi = 1'b1;
        strobe.incPc  = 1'b1;
        nextCyc       = MC4;
      end
      MC4: begin
        strobe.loadAcc = 1'b1;
        strobe.useTmp  = 1'b1;
        lastCyc        = 1'b1;
      end
      default: lastCyc = 1'b1;
    endcase
    if (!busDone) begin
      strobe.loadIr  = 1'b0;
      strobe.incPc   = 1'b0;
      strobe.addAcc  = 1'b0;
      strobe.loadAcc = 1'b0;
      strobe.loadLo  = 1'b0;
      strobe.loadHi  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curCyc    <= MC1;
      instrDone <= 1'b0;
    end else begin
      instrDone <= busDone && lastCyc;
      if (busDone) curCyc <= nextCyc;
    end
  end

  assign cycType = (curCyc == MC1) ? CYC_FETCH : CYC_READ;
  assign mCycle  = curCyc;

  // R8: machine-cycle number moves only after a completion strobe
  p_cycle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busDone)) |-> $stable(mCycle));

  // R9: completion pulse lasts one clock
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> !instrDone);

  // R2: an instruction always finishes with the sequencer back at cycle 1
  p_restart_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> (mCycle == 3'd1));

  // R5: cycles 3 and 4 occur only under load-direct
  p_deep_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (mCycle > 3'd2) |-> (irQ == OP_LOADDIR));
endmodule

// File: rtl/mcycle_seq_datapath.sv
module mcycle_seq_datapath
  import mcycle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] pcQ,
  output logic [DATA_W-1:0] irQ,
  output logic [ADDR_W-1:0] tmpQ,
  output logic [DATA_W-1:0] accQ,
  output logic              carryQ
);
  localparam int HALF = ADDR_W / 2;

  logic [DATA_W:0] sumWide;
  assign sumWide = {1'b0, accQ} + {1'b0, busData};

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ    <= '0;
      irQ    <= '0;
      tmpQ   <= '0;
      accQ   <= '0;
      carryQ <= 1'b0;
    end else begin
      if (strobe.incPc)  pcQ <= pcQ + 1'b1;
      if (strobe.loadIr) irQ <= busData;
      if (strobe.loadLo) tmpQ[HALF-1:0] <= busData;
      if (strobe.loadHi) tmpQ[ADDR_W-1:HALF] <= busData;
      if (strobe.addAcc) begin
        accQ   <= sumWide[DATA_W-1:0];
        carryQ <= sumWide[DATA_W];
      end else if (strobe.loadAcc) begin
        accQ <= busData;
      end
    end
  end

  assign busAddr = strobe.useTmp ? tmpQ : pcQ;

  // R6: the program counter only ever steps forward by one
  p_pc_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(pcQ)) |-> (pcQ == $past(pcQ) + 1'b1));

  // R5: the load-direct data read leaves the program counter alone
  p_no_pc_on_data_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.loadAcc |=> $stable(pcQ));

  // R4: carry moves only on an add
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !strobe.addAcc |=> $stable(carryQ));
endmodule

// File: rtl/mcycle_sequencer.sv
module mcycle_sequencer
  import mcycle_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busDone,
  input  logic [7:0]        busData,
  output logic [2:0]        cycType,
  output logic [15:0]       busAddr,
  output logic [2:0]        mCycle,
  output logic [15:0]       pc,
  output logic [7:0]        ir,
  output logic [15:0]       tmpAddr,
  output logic [7:0]        acc,
  output logic              carry,
  output logic              instrDone
);
  seqStrobe_t strobe;
  logic [DATA_W-1:0] irQ;

  mcycle_seq_control i_control (
    .clk       (clk),
    .rst       (rst),
    .busDone   (busDone),
    .busData   (busData),
    .irQ       (irQ),
    .strobe    (strobe),
    .cycType   (cycType),
    .mCycle    (mCycle),
    .instrDone (instrDone)
  );

  mcycle_seq_datapath i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .busData (busData),
    .busAddr (busAddr),
    .pcQ     (pc),
    .irQ     (irQ),
    .tmpQ    (tmpAddr),
    .accQ    (acc),
    .carryQ  (carry)
  );

  assign ir = irQ;

  // R8: request stays steady until the cycle completes
  p_req_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busDone)) |-> ($stable(busAddr) && $stable(cycType)));

  // R3: only the first cycle of an instruction may be a fetch
  p_read_type_r3: assert property (@(posedge clk) disable iff (rst)
    (mCycle != 3'd1) |-> (cycType == 3'b010));
endmodule

// File: tb/test_mcycle_sequencer.sv
module test_mcycle_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busDone;
  logic [7:0]  busData;
  logic [2:0]  cycType;
  logic [15:0] busAddr;
  logic [2:0]  mCycle;
  logic [15:0] pc;
  logic [7:0]  ir;
  logic [15:0] tmpAddr;
  logic [7:0]  acc;
  logic        carry;
  logic        instrDone;

  always #10 clk = ~clk;   // 50 MHz

  mcycle_sequencer i_mcycle_sequencer (
    .clk(clk), .rst(rst), .busDone(busDone), .busData(busData),
    .cycType(cycType), .busAddr(busAddr), .mCycle(mCycle), .pc(pc),
    .ir(ir), .tmpAddr(tmpAddr), .acc(acc), .carry(carry), .instrDone(instrDone)
  );

  // bus cycle generator model: fetch lasts 4 states, read lasts 3
  logic [7:0] mem [256];
  int tState;
  int cycLen;
  assign cycLen  = (cycType == 3'b011) ? 4 : 3;
  assign busDone = (tState == cycLen);
  assign busData = mem[busAddr[7:0]] ^ busAddr[15:8];

  always_ff @(posedge clk) begin
    if (rst)          tState <= 1;
    else if (busDone) tState <= 1;
    else              tState <= tState + 1;
  end

  // per-cycle log of completed machine cycles
  logic [2:0]  logType [64];
  logic [15:0] logAddr [64];
  logic [2:0]  logCyc  [64];
  int logN = 0;
  always @(negedge clk) begin
    if (!rst && busDone && logN < 64) begin
      logType[logN] <= cycType;
      logAddr[logN] <= busAddr;
      logCyc[logN]  <= mCycle;
      logN          <= logN + 1;
    end
  end

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input string what, input longint actual, input longint expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  // {states, acc, carry, pc, ir, tmpAddr}
  localparam int NV = 10;
  localparam logic [63:0] VEC [NV] = '{
    {8'd7,  8'h05, 8'h0, 16'h0002, 8'hC6, 16'h0000},  // R4 plain add
    {8'd7,  8'h04, 8'h1, 16'h0004, 8'hC6, 16'h0000},  // R4 carry out
    {8'd13, 8'h53, 8'h1, 16'h0007, 8'h3A, 16'h42F0},  // R5 load, carry kept
    {8'd4,  8'h53, 8'h1, 16'h0008, 8'h00, 16'h42F0},  // R7 nop 00
    {8'd7,  8'h00, 8'h1, 16'h000A, 8'hC6, 16'h42F0},  // R4 sum exactly 256
    {8'd13, 8'hC6, 8'h1, 16'h000D, 8'h3A, 16'h0000},  // R5 address 0000
    {8'd7,  8'hC7, 8'h0, 16'h000F, 8'hC6, 16'h0000},  // R4 carry cleared
    {8'd4,  8'hC7, 8'h0, 16'h0010, 8'hFF, 16'h0000},  // R7 nop FF
    {8'd13, 8'hF0, 8'h0, 16'h0013, 8'h3A, 16'hFFFF},  // R5 address FFFF
    {8'd7,  8'h00, 8'h1, 16'h0015, 8'hC6, 16'hFFFF}   // R4 wrap to zero
  };

  task automatic runInstr(input int idx, input logic [63:0] v);
    int cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!instrDone && cnt < 100);
    check("R9", $sformatf("instr %0d states", idx), cnt, v[63:56]);
    check("R4/R5", $sformatf("instr %0d acc", idx), acc, v[55:48]);
    check("R4", $sformatf("instr %0d carry", idx), carry, v[40]);
    check("R6", $sformatf("instr %0d pc", idx), pc, v[39:24]);
    check("R2", $sformatf("instr %0d ir", idx), ir, v[23:16]);
    check("R5", $sformatf("instr %0d tmpAddr", idx), tmpAddr, v[15:0]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h00] = 8'hC6; mem[8'h01] = 8'h05;
    mem[8'h02] = 8'hC6; mem[8'h03] = 8'hFF;
    mem[8'h04] = 8'h3A; mem[8'h05] = 8'hF0; mem[8'h06] = 8'h42;
    mem[8'h07] = 8'h00;
    mem[8'h08] = 8'hC6; mem[8'h09] = 8'hAD;
    mem[8'h0A] = 8'h3A; mem[8'h0B] = 8'h00; mem[8'h0C] = 8'h00;
    mem[8'h0D] = 8'hC6; mem[8'h0E] = 8'h01;
    mem[8'h0F] = 8'hFF;
    mem[8'h10] = 8'h3A; mem[8'h11] = 8'hFF; mem[8'h12] = 8'hFF;
    mem[8'h13] = 8'hC6; mem[8'h14] = 8'h10;
    mem[8'hF0] = 8'h11;
    mem[8'hFF] = 8'h0F;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pc", pc, 16'h0000);
    check("R1", "acc", acc, 8'h00);
    check("R1", "carry", carry, 1'b0);
    check("R1", "mCycle", mCycle, 3'd1);
    check("R1", "cycType", cycType, 3'b011);
    check("R1", "busAddr", busAddr, 16'h0000);
    check("R1", "instrDone", instrDone, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) runInstr(k, VEC[k]);

    // R2/R3/R5/R6/R8: cycle log of the first load-direct (log entries 4..7) and following nop
    check("R2", "log4 type", logType[4], 3'b011);
    check("R2", "log4 addr", logAddr[4], 16'h0004);
    check("R8", "log4 cycle", logCyc[4], 3'd1);
    check("R3", "log5 type", logType[5], 3'b010);
    check("R8", "log5 cycle", logCyc[5], 3'd2);
    check("R6", "log6 addr", logAddr[6], 16'h0006);
    check("R8", "log6 cycle", logCyc[6], 3'd3);
    check("R5", "log7 addr", logAddr[7], 16'h42F0);
    check("R3", "log7 type", logType[7], 3'b010);
    check("R8", "log7 cycle", logCyc[7], 3'd4);
    check("R7", "log8 addr", logAddr[8], 16'h0007);
    check("R8", "log8 cycle", logCyc[8], 3'd1);

    // R9: pulse already low one clock later
    @(negedge clk);
    check("R9", "pulse width", instrDone, 1'b0);

    // R10: reset in the middle of a load-direct
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    runInstr(100, VEC[0]);
    runInstr(101, VEC[1]);
    begin
      int w = 0;
      while (mCycle != 3'd3 && w < 50) begin @(negedge clk); w++; end
    end
    check("R5", "mid load cycle", mCycle, 3'd3);
    rst = 1'b1;
    @(negedge clk);
    check("R10", "pc after reset", pc, 16'h0000);
    check("R10", "acc after reset", acc, 8'h00);
    check("R10", "mCycle after reset", mCycle, 3'd1);
    check("R10", "addr after reset", busAddr, 16'h0000);
    check("R10", "type after reset", cycType, 3'b011);
    rst = 1'b0;
    runInstr(102, VEC[0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule